// File: doc/BRIEF.md
# Credit-Window Packet Gate

This block sits on a packet stream of 64-bit beats with valid/ready handshakes. It limits how many packets the sender may have outstanding toward a consumer that has not yet confirmed them. Beats pass straight from the input port to the output port with no added latency. Each packet that completes on the output advances a free-running sent-packet counter.

A second inbound stream carries acknowledgement packets from the consumer. Each acknowledgement is two beats long. The first beat is a header and is not interpreted. The last beat reports the sequence number of the newest packet the consumer has finished with. It also carries a flag that suspends the window limit while the flag is set.

The window size is written over a simple settings bus, made of a strobe, an address and data. A synchronous clear input returns the counters to their reset relationship. All counter arithmetic is modulo 2^SEQ_W, so the counter and the acknowledgements may wrap without stalling the stream and without releasing extra packets.

Top module: `credit_window_gate`

## Requirements
- R1: After reset, with no input offered, `out_valid` is low and `fc_ready` is high. A full window of packets is accepted immediately: the acknowledged value starts at the counter value minus one.
- R2: A settings write with `set_addr` equal to WIN_ADDR (0) loads `set_data` as the window size from the next cycle. A write to any other address leaves the window unchanged.
- R3: A new packet may start only while (sent − acknowledged) mod 2^SEQ_W ≤ window, where sent counts the packets already sent. While a new packet is blocked, `in_ready` and `out_valid` are both low. With window W, the block has at most W unacknowledged packets.
- R4: Once the first beat of a packet has been accepted, its remaining beats pass through to the beat with `in_last` set. Neither the window check nor a window write interrupts them.
- R5: The sent counter advances by one on each accepted beat that has `in_last` set. A multi-beat packet therefore uses a single window slot.
- R6: `fc_ready` is always high. The acknowledged number is taken from bits SEQ_W−1:0 of the flow-control beat that has `fc_last` set. A beat without `fc_last` (the header) changes nothing.
- R7: An acknowledgement that repeats the previously reported number frees no slot.
- R8: The counter wraps from all-ones to zero. Acknowledgements on either side of the wrap free exactly the number of slots that the modular difference implies.
- R9: Bit 32 of the final acknowledgement beat is an override flag. While the latest acknowledgement has it set, packets start regardless of the window. An acknowledgement with the flag clear restores the limit.
- R10: `clear` resets the sent counter to zero, the acknowledged value to all-ones, the override flag to clear and any packet in progress. The window size is kept.
- R11: `out_data` and `out_last` equal `in_data` and `in_last`. `in_ready` is never high while `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous return to the post-reset counter state |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | ADDR_W | Settings write address |
| set_data | input | CFG_W | Settings write data |
| fc_data | input | DATA_W | Acknowledgement stream beat |
| fc_last | input | 1 | Final acknowledgement beat |
| fc_valid | input | 1 | Acknowledgement beat valid |
| fc_ready | output | 1 | Acknowledgement stream ready (always high) |
| in_data | input | DATA_W | Inbound packet beat |
| in_last | input | 1 | Final beat of the inbound packet |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Inbound beat accepted |
| out_data | output | DATA_W | Outbound packet beat |
| out_last | output | 1 | Final beat of the outbound packet |
| out_valid | output | 1 | Outbound beat valid |
| out_ready | input | 1 | Outbound beat taken by the downstream side |

## Verification
The bench builds the block with SEQ_W = 8 and WIN_INIT = 2, and leaves the data width at 64. An 8-bit counter wraps after 256 packets, so a directed loop of single-beat packets reaches the wrap point in a few thousand cycles. The bench then sends acknowledgements just before, at and just after the wrap, and checks how many slots each one frees. The small initial window makes the blocked state reachable after the second packet. This exercises repeated acknowledgements, the override flag, clear, and window changes in the middle of a packet.

// File: rtl/credit_window_pkg.sv
// Package: shared constants and helpers for the credit-window gate.
// Assumes acknowledgement beats are at least 33 bits wide.
package credit_window_pkg;

    // Bit of the final acknowledgement beat that suspends the window limit.
    localparam int ACK_OVR_BIT = 32;

    // Larger of two widths, used to size the window comparison.
    function automatic int width_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cw_settings.sv
// cw_settings: holds the window size written over the settings bus.
// Assumes a write lands in one cycle. The clear input does not touch the window.
module cw_settings #(
    parameter int ADDR_W   = 8,
    parameter int CFG_W    = 32,
    parameter int WIN_ADDR = 0,
    parameter int WIN_INIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [CFG_W-1:0]  set_data,
    output logic [CFG_W-1:0]  window
);

    localparam logic [ADDR_W-1:0] WIN_SEL = ADDR_W'(WIN_ADDR);

    logic hit;
    assign hit = set_stb && (set_addr == WIN_SEL);

    // Window register: load on a matching settings write.
    always_ff @(posedge clk) begin
        if (!rst_n)   window <= CFG_W'(WIN_INIT);
        else if (hit) window <= set_data;
    end

    p_window_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> window == $past(set_data));
    p_window_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(window));

endmodule

// File: rtl/cw_ack_rx.sv
// cw_ack_rx: accepts the acknowledgement stream and keeps the latest
// acknowledged sequence number and override flag. The stream is always
// accepted. Only the beat marked last is used; header beats are not parsed.
module cw_ack_rx #(
    parameter int DATA_W  = 64,
    parameter int SEQ_W   = 32,
    parameter int OVR_BIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [DATA_W-1:0] fc_data,
    input  logic              fc_last,
    input  logic              fc_valid,
    output logic              fc_ready,
    output logic [SEQ_W-1:0]  ack_seq,
    output logic              ack_ovr
);

    logic take;
    assign take     = fc_valid && fc_last;
    assign fc_ready = 1'b1;

    // Acknowledgement state: all-ones (counter start minus one) after reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ack_seq <= '1;
            ack_ovr <= 1'b0;
        end else if (take) begin
            ack_seq <= fc_data[SEQ_W-1:0];
            ack_ovr <= fc_data[OVR_BIT];
        end
    end

    p_ack_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear) |=> ack_seq == $past(fc_data[SEQ_W-1:0]));
    p_header_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid && !fc_last && !clear) |=> ($stable(ack_seq) && $stable(ack_ovr)));
    p_override_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear) |=> ack_ovr == $past(fc_data[OVR_BIT]));

endmodule

// File: rtl/cw_seq_gate.sv
// cw_seq_gate: passes beats from input to output and counts finished
// packets. A new packet starts only inside the credit window or while the
// override flag is set. A packet that has started is never cut.
// Assumes the acknowledged value never runs ahead of the sent counter.
module cw_seq_gate #(
    parameter int DATA_W = 64,
    parameter int SEQ_W  = 32,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [CFG_W-1:0]  window,
    input  logic [SEQ_W-1:0]  ack_seq,
    input  logic              ack_ovr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int CMP_W = credit_window_pkg::width_max(SEQ_W, CFG_W);

    logic [SEQ_W-1:0] sent_q;
    logic             busy_q;
    logic [SEQ_W-1:0] span;
    logic [CMP_W-1:0] span_x;
    logic [CMP_W-1:0] win_x;
    logic             credit_ok;
    logic             go;
    logic             xfer;

    // Window test: modular distance from the last acknowledgement to the next number.
    always_comb begin
        span      = sent_q - ack_seq;
        span_x    = CMP_W'(span);
        win_x     = CMP_W'(window);
        credit_ok = (span_x <= win_x);
        go        = busy_q || ack_ovr || credit_ok;
    end

    assign out_data  = in_data;
    assign out_last  = in_last;
    assign out_valid = in_valid && go;
    assign in_ready  = out_ready && go;
    assign xfer      = in_valid && in_ready;

    // Packet framing and sent counter: advance on each accepted final beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sent_q <= '0;
            busy_q <= 1'b0;
        end else if (xfer) begin
            busy_q <= !in_last;
            if (in_last) sent_q <= sent_q + 1'b1;
        end
    end

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && in_last && !clear) |=> sent_q == $past(sent_q) + 1'b1);
    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(xfer && in_last) && !clear) |=> $stable(sent_q));
    p_no_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (out_valid == in_valid));
    p_ready_needs_sink_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);
    p_clear_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sent_q == '0 && !busy_q));

endmodule

// File: rtl/credit_window_gate.sv
// credit_window_gate: top level of the credit-window packet gate. It ties
// together the settings register, the acknowledgement receiver and the gated
// pass-through. The data path has no storage; only control state is registered.
module credit_window_gate #(
    parameter int DATA_W   = 64,
    parameter int SEQ_W    = 32,
    parameter int ADDR_W   = 8,
    parameter int CFG_W    = 32,
    parameter int WIN_ADDR = 0,
    parameter int WIN_INIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              set_stb,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [CFG_W-1:0]  set_data,
    input  logic [DATA_W-1:0] fc_data,
    input  logic              fc_last,
    input  logic              fc_valid,
    output logic              fc_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);

    logic [CFG_W-1:0] window;
    logic [SEQ_W-1:0] ack_seq;
    logic             ack_ovr;

    cw_settings #(
        .ADDR_W(ADDR_W), .CFG_W(CFG_W), .WIN_ADDR(WIN_ADDR), .WIN_INIT(WIN_INIT)
    ) u_settings (
        .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_addr(set_addr),
        .set_data(set_data), .window(window)
    );

    cw_ack_rx #(
        .DATA_W(DATA_W), .SEQ_W(SEQ_W), .OVR_BIT(credit_window_pkg::ACK_OVR_BIT)
    ) u_ack (
        .clk(clk), .rst_n(rst_n), .clear(clear), .fc_data(fc_data),
        .fc_last(fc_last), .fc_valid(fc_valid), .fc_ready(fc_ready),
        .ack_seq(ack_seq), .ack_ovr(ack_ovr)
    );

    cw_seq_gate #(
        .DATA_W(DATA_W), .SEQ_W(SEQ_W), .CFG_W(CFG_W)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .clear(clear), .window(window),
        .ack_seq(ack_seq), .ack_ovr(ack_ovr), .in_data(in_data),
        .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_last(out_last), .out_valid(out_valid),
        .out_ready(out_ready)
    );

endmodule

// File: tb/credit_window_gate_test.sv
module credit_window_gate_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          set_stb = 1'b0;
    logic [7:0]    set_addr = '0;
    logic [31:0]   set_data = '0;
    logic [DW-1:0] fc_data = '0;
    logic          fc_last = 1'b0;
    logic          fc_valid = 1'b0;
    logic          fc_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] out_data;
    logic          out_last;
    logic          out_valid;
    logic          out_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [SW-1:0] exp_sent = '0;
    logic [SW-1:0] exp_ack = '1;
    int            exp_win = 2;
    bit            exp_ovr = 1'b0;
    logic [31:0]   beat_tag = 32'h100;

    always #(CLK_PERIOD/2) clk = ~clk;

    credit_window_gate #(.DATA_W(DW), .SEQ_W(SW), .WIN_INIT(2)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .set_stb(set_stb),
        .set_addr(set_addr), .set_data(set_data), .fc_data(fc_data),
        .fc_last(fc_last), .fc_valid(fc_valid), .fc_ready(fc_ready),
        .in_data(in_data), .in_last(in_last), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_last(out_last),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic check_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Slots the model says are free: window minus unacknowledged packets.
    function automatic int credits_left();
        logic [SW-1:0] outst;
        outst = exp_sent - exp_ack - 1'b1;
        if (exp_ovr) return 1 << 20;
        if (int'(outst) >= exp_win) return 0;
        return exp_win - int'(outst);
    endfunction

    // Offer k single-beat packets, one per cycle; compare the accepted count and the data.
    task automatic offer_burst(input int k, input string req);
        int got = 0;
        int bad = 0;
        int want;
        want = credits_left();
        if (want > k) want = k;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            beat_tag = beat_tag + 1;
            in_valid = 1'b1;
            in_last  = 1'b1;
            in_data  = {32'hC0DE_0000, beat_tag};
            #1;
            if (in_ready) begin
                got++;
                if (!out_valid || out_data != in_data || !out_last) bad++;
            end else if (out_valid) begin
                bad++;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check_eq({req, " accepted"}, got, want);
        check_eq("R11 pass-through mismatches", bad, 0);
        exp_sent = exp_sent + SW'(want);
    endtask

    task automatic send_ack(input logic [SW-1:0] val, input bit ovr);
        @(negedge clk);
        fc_valid = 1'b1;
        fc_last  = 1'b0;
        fc_data  = {1'b1, 3'b000, 12'h0AB, 16'd4, 32'h0000_00C3};
        #1;
        check_eq("R6 fc_ready", fc_ready, 1);
        @(negedge clk);
        fc_last = 1'b1;
        fc_data = {31'h0, ovr, 24'h0, val};
        @(negedge clk);
        fc_valid = 1'b0;
        fc_last  = 1'b0;
        exp_ack  = val;
        exp_ovr  = ovr;
    endtask

    task automatic set_win(input logic [7:0] addr, input int val);
        @(negedge clk);
        set_stb  = 1'b1;
        set_addr = addr;
        set_data = 32'(val);
        @(negedge clk);
        set_stb = 1'b0;
        if (addr == 8'd0) exp_win = val;
    endtask

    task automatic ack_all();
        send_ack(exp_sent - 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1 out_valid idle after reset", out_valid, 0);
        check_eq("R1 fc_ready after reset", fc_ready, 1);
        offer_burst(4, "R1 full window after reset");
        offer_burst(3, "R3 blocked at window");
    endtask

    task automatic t_acks();
        send_ack(8'd1, 1'b0);
        offer_burst(4, "R6 ack frees two");
        send_ack(8'd1, 1'b0);
        offer_burst(3, "R7 repeated ack frees none");
        send_ack(8'd2, 1'b0);
        offer_burst(3, "R6 ack frees one");
    endtask

    task automatic t_settings();
        set_win(8'd5, 0);
        ack_all();
        offer_burst(5, "R2 other address ignored");
        set_win(8'd0, 3);
        ack_all();
        offer_burst(5, "R2 window write");
    endtask

    // Three-beat packet with window set to zero after its first beat.
    task automatic t_multibeat();
        ack_all();
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_last = 1'b0; in_data = 64'hAAAA_0001;
        #1;
        check_eq("R11 in_ready low without sink", in_ready, 0);
        check_eq("R11 out_valid offered", out_valid, 1);
        out_ready = 1'b1;
        #1;
        check_eq("R4 first beat accepted", in_ready, 1);
        @(negedge clk);
        in_data = 64'hAAAA_0002;
        set_stb = 1'b1; set_addr = 8'd0; set_data = 32'd0;
        #1;
        check_eq("R4 middle beat accepted", in_ready, 1);
        @(negedge clk);
        set_stb = 1'b0;
        exp_win = 0;
        in_data = 64'hAAAA_0003; in_last = 1'b1;
        #1;
        check_eq("R4 last beat after window shrink", in_ready, 1);
        check_eq("R11 out_last follows", out_last, 1);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        exp_sent = exp_sent + 1'b1;
        offer_burst(3, "R3 window zero blocks");
        set_win(8'd0, 3);
        offer_burst(4, "R5 multi-beat uses one slot");
    endtask

    task automatic t_override();
        send_ack(exp_ack, 1'b1);
        offer_burst(6, "R9 override passes all");
        ack_all();
        offer_burst(5, "R9 override cleared");
    endtask

    task automatic t_clear_wrap();
        set_win(8'd0, 4);
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_sent = '0; exp_ack = '1; exp_ovr = 1'b0;
        offer_burst(6, "R10 window after clear");
        while (exp_sent != 8'd252) begin
            ack_all();
            offer_burst(6, "R8 approach wrap");
        end
        ack_all();
        offer_burst(6, "R8 send across wrap");
        check_eq("R8 counter wrapped", exp_sent, 0);
        send_ack(8'hFE, 1'b0);
        offer_burst(6, "R8 ack before wrap");
        send_ack(8'h00, 1'b0);
        offer_burst(6, "R8 ack at zero");
        send_ack(8'h02, 1'b0);
        offer_burst(6, "R8 ack after wrap");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_acks();
        t_settings();
        t_multibeat();
        t_override();
        t_clear_wrap();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule